// File: doc/BRIEF.md
# DMA Address Hold Loop Generator

This block generates the byte address for every beat of a DMA transfer, once for the read side and once for the write side. Each side holds a base address and a running address. In linear mode every beat moves the address forward by the beat size. In hold mode the address stays inside a small power-of-two window that starts at the base, and it returns to the base when it reaches the end of the window. Hold mode is meant for peripherals whose FIFO is mapped over a few bytes.

Hold mode is set up with a size write. A size of zero turns hold mode off for the selected side. A size of 1, 2, 4 or 8 bytes turns it on and stores the log2 of the size in a mode word. Any other size leaves the mode word as it was. A load strobe captures a new base and restarts that side at the base. Each advance strobe then steps the address by one beat. Both sides use the same beat size but run on their own strobes. The data path and the bus protocol are outside this block. The interface is made of plain strobes and carries no back-pressure.

Top module: `dma_hold_addr_gen`

## Requirements
- R1: After reset both addresses are 0 and every bit of `mode_o` is 0.
- R2: One cycle after a load strobe, that side's address equals the base presented with the load. This also holds when an advance strobe is high in the same cycle.
- R3: In linear mode each advance adds the beat size, 1 << `beat_code` bytes (codes 0..3 give 1, 2, 4 and 8 bytes), modulo 2^AW.
- R4: In hold mode with window L = 1 << code, the address after k advances is base + ((k × beat) mod L), modulo 2^AW.
- R5: In hold mode, when the beat size is larger than L, the address stays at the base on every advance.
- R6: While a side has neither a load nor an advance, its address does not change.
- R7: A size write of 1, 2, 4 or 8 sets the selected side's enable bit and stores the code log2(size). The fields in `mode_o` are: read side enable at bit 12 and code at bits 15:14; write side enable at bit 13 and code at bits 17:16. All other bits stay 0. `cfg_dst` = 0 selects the read side and 1 selects the write side.
- R8: A size write of 0 clears only the selected side's enable bit. That side's code bits are kept.
- R9: A size write of any other value, or a cycle with no write, leaves `mode_o` unchanged.
- R10: Strobes on one side never move the other side's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Size write strobe |
| cfg_dst | input | 1 | Side selected by the write (0 read, 1 write) |
| cfg_size | input | SIZE_W | Requested hold size in bytes, 0 turns hold off |
| beat_code | input | 2 | log2 of the beat size in bytes |
| src_base | input | AW | Read side base address |
| src_load | input | 1 | Read side load strobe |
| src_adv | input | 1 | Read side beat advance |
| dst_base | input | AW | Write side base address |
| dst_load | input | 1 | Write side load strobe |
| dst_adv | input | 1 | Write side beat advance |
| src_addr | output | AW | Read side current address |
| dst_addr | output | AW | Write side current address |
| mode_o | output | 32 | Mode word holding the hold fields |

## Verification
The window assertions compare each address with a base that the checker captures on every load, so they assume the base inputs are only sampled on load cycles. The stimulus always loads a side before it advances that side and changes the mode only between runs. The linear and hold assertions read the mode from the cycle of the advance, so the bench never writes the size in the same cycle as an advance of the side being written. The sweeps cover every hold code, every beat code and bases close to the top of the address space, so the cases where the address wraps past 2^AW are exercised.

// File: rtl/dma_hold_pkg.sv
package dma_hold_pkg;
  localparam int MODE_W       = 32;
  localparam int CODE_W       = 2;
  localparam int SRC_EN_BIT   = 12;
  localparam int DST_EN_BIT   = 13;
  localparam int SRC_CODE_LSB = 14;
  localparam int DST_CODE_LSB = 16;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } hold_cfg_t;

  typedef struct packed {
    logic              legal;
    logic              off;
    logic [CODE_W-1:0] code;
  } size_dec_t;

  // Decode a requested byte size into hold fields.
  function automatic size_dec_t decode_size(input int unsigned sz);
    size_dec_t d;
    d = '0;
    case (sz)
      0:       begin d.legal = 1'b1; d.off = 1'b1; end
      1:       begin d.legal = 1'b1; d.code = 2'd0; end
      2:       begin d.legal = 1'b1; d.code = 2'd1; end
      4:       begin d.legal = 1'b1; d.code = 2'd2; end
      8:       begin d.legal = 1'b1; d.code = 2'd3; end
      default: d.legal = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/hold_mode_reg.sv
module hold_mode_reg
  import dma_hold_pkg::*;
#(
  parameter int SIZE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic                         cfg_dst,
  input  logic [SIZE_W-1:0]            cfg_size,
  output hold_cfg_t [1:0]              side_cfg,
  output logic [MODE_W-1:0]            mode_word
);
  size_dec_t dec;
  assign dec = decode_size(32'(cfg_size));

  for (genvar s = 0; s < 2; s++) begin : g_side
    hold_cfg_t q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (cfg_we && (cfg_dst == 1'(s)) && dec.legal) begin
        if (dec.off) q.en <= 1'b0;
        else         q    <= '{en: 1'b1, code: dec.code};
      end
    end
    assign side_cfg[s] = q;
  end

  always_comb begin
    mode_word = '0;
    mode_word[SRC_EN_BIT]                 = side_cfg[0].en;
    mode_word[DST_EN_BIT]                 = side_cfg[1].en;
    mode_word[SRC_CODE_LSB +: CODE_W]     = side_cfg[0].code;
    mode_word[DST_CODE_LSB +: CODE_W]     = side_cfg[1].code;
  end
endmodule

// File: rtl/hold_addr_unit.sv
module hold_addr_unit
  import dma_hold_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_i,
  input  logic          load_i,
  input  logic          adv_i,
  input  hold_cfg_t     cfg_i,
  input  logic [1:0]    beat_code_i,
  output logic [AW-1:0] addr_o
);
  localparam int LB_W = 4;

  logic [AW-1:0]   base_q, addr_q, step, mask, nxt;
  logic [LB_W-1:0] loop_b, beat_b;

  assign loop_b = 4'd1 << cfg_i.code;
  assign beat_b = 4'd1 << beat_code_i;
  assign step   = AW'(beat_b);
  assign mask   = AW'(loop_b) - AW'(1);

  always_comb begin
    if (!cfg_i.en)            nxt = addr_q + step;
    else if (beat_b > loop_b) nxt = base_q;
    else                      nxt = base_q + ((addr_q - base_q + step) & mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      addr_q <= base_i;
    end else if (adv_i) begin
      addr_q <= nxt;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_hold_addr_gen.sv
module dma_hold_addr_gen
  import dma_hold_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_dst,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [1:0]        beat_code,
  input  logic [AW-1:0]     src_base,
  input  logic              src_load,
  input  logic              src_adv,
  input  logic [AW-1:0]     dst_base,
  input  logic              dst_load,
  input  logic              dst_adv,
  output logic [AW-1:0]     src_addr,
  output logic [AW-1:0]     dst_addr,
  output logic [MODE_W-1:0] mode_o
);
  hold_cfg_t [1:0]        side_cfg;
  logic [1:0][AW-1:0]     base_v, addr_v;
  logic [1:0]             load_v, adv_v;

  assign base_v = {dst_base, src_base};
  assign load_v = {dst_load, src_load};
  assign adv_v  = {dst_adv, src_adv};

  hold_mode_reg #(.SIZE_W(SIZE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dst(cfg_dst),
    .cfg_size(cfg_size), .side_cfg(side_cfg), .mode_word(mode_o)
  );

  for (genvar s = 0; s < 2; s++) begin : g_unit
    hold_addr_unit #(.AW(AW)) u_unit (
      .clk(clk), .rst_n(rst_n), .base_i(base_v[s]), .load_i(load_v[s]),
      .adv_i(adv_v[s]), .cfg_i(side_cfg[s]), .beat_code_i(beat_code),
      .addr_o(addr_v[s])
    );
  end

  assign src_addr = addr_v[0];
  assign dst_addr = addr_v[1];
endmodule

// File: rtl/dma_hold_addr_gen_chk.sv
module dma_hold_addr_gen_chk
  import dma_hold_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [SIZE_W-1:0] cfg_size,
  input logic [1:0]        beat_code,
  input logic [AW-1:0]     src_base,
  input logic              src_load,
  input logic              src_adv,
  input logic [AW-1:0]     dst_base,
  input logic              dst_load,
  input logic              dst_adv,
  input logic [AW-1:0]     src_addr,
  input logic [AW-1:0]     dst_addr,
  input logic [5:0]        mode_bits
);
  logic [AW-1:0] trk_src, trk_dst;
  logic [3:0]    beat_b, src_l, dst_l;
  logic          src_hold, dst_hold, size_bad;
  size_dec_t     dec;

  assign dec      = decode_size(32'(cfg_size));
  assign size_bad = !dec.legal;
  assign src_hold = mode_bits[0];
  assign dst_hold = mode_bits[1];
  assign src_l    = 4'd1 << mode_bits[3:2];
  assign dst_l    = 4'd1 << mode_bits[5:4];
  assign beat_b   = 4'd1 << beat_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_src <= '0;
      trk_dst <= '0;
    end else begin
      if (src_load) trk_src <= src_base;
      if (dst_load) trk_dst <= dst_base;
    end
  end

  // R2
  src_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_load |=> src_addr == $past(src_base));
  // R2
  dst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_load |=> dst_addr == $past(dst_base));
  // R3
  src_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_adv && !src_load && !src_hold) |=> (src_addr - $past(src_addr)) == AW'($past(beat_b)));
  // R4
  src_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_adv && !src_load && src_hold) |=> (src_addr - trk_src) < AW'($past(src_l)));
  // R4
  dst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_adv && !dst_load && dst_hold) |=> (dst_addr - trk_dst) < AW'($past(dst_l)));
  // R5
  src_big_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_adv && !src_load && src_hold && (beat_b > src_l)) |=> src_addr == trk_src);
  // R6
  src_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_load && !src_adv) |=> $stable(src_addr));
  // R10
  dst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dst_load && !dst_adv) |=> $stable(dst_addr));
  // R9
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || size_bad) |=> $stable(mode_bits));
endmodule

bind dma_hold_addr_gen dma_hold_addr_gen_chk #(.AW(AW), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_size(cfg_size),
  .beat_code(beat_code), .src_base(src_base), .src_load(src_load),
  .src_adv(src_adv), .dst_base(dst_base), .dst_load(dst_load),
  .dst_adv(dst_adv), .src_addr(src_addr), .dst_addr(dst_addr),
  .mode_bits(mode_o[17:12])
);

// File: tb/dma_hold_addr_gen_tb.sv
`timescale 1ns/1ps
module dma_hold_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_dst = 1'b0;
  logic [7:0]  cfg_size = '0;
  logic [1:0]  beat_code = '0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic        src_load = 1'b0, src_adv = 1'b0, dst_load = 1'b0, dst_adv = 1'b0;
  logic [31:0] src_addr, dst_addr, mode_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model of the mode fields
  logic       m_en [2];
  logic [1:0] m_code [2];

  always #2 clk = ~clk;

  dma_hold_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dst(cfg_dst),
    .cfg_size(cfg_size), .beat_code(beat_code), .src_base(src_base),
    .src_load(src_load), .src_adv(src_adv), .dst_base(dst_base),
    .dst_load(dst_load), .dst_adv(dst_adv), .src_addr(src_addr),
    .dst_addr(dst_addr), .mode_o(mode_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mode();
    logic [31:0] w = '0;
    w[12] = m_en[0]; w[13] = m_en[1];
    w[15:14] = m_code[0]; w[17:16] = m_code[1];
    return w;
  endfunction

  task automatic write_size(input int side, input int sz);
    cfg_we = 1'b1; cfg_dst = side[0]; cfg_size = sz[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
    case (sz)
      0: m_en[side] = 1'b0;
      1: begin m_en[side] = 1'b1; m_code[side] = 2'd0; end
      2: begin m_en[side] = 1'b1; m_code[side] = 2'd1; end
      4: begin m_en[side] = 1'b1; m_code[side] = 2'd2; end
      8: begin m_en[side] = 1'b1; m_code[side] = 2'd3; end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] side_addr(input int side);
    return side == 0 ? src_addr : dst_addr;
  endfunction

  task automatic drive(input int side, input logic ld, input logic adv, input logic [31:0] b);
    if (side == 0) begin src_load = ld; src_adv = adv; src_base = b; end
    else           begin dst_load = ld; dst_adv = adv; dst_base = b; end
  endtask

  // One run: load a base, advance 12 beats, then idle.
  task automatic run(input int side, input int hold, input int bc, input logic [31:0] b);
    logic [31:0] other, e;
    int beat, lsz;
    beat = 1 << bc; lsz = (hold < 0) ? 0 : (1 << hold);
    write_size(side, lsz);
    chk((lsz == 0) ? "R8" : "R7", mode_o, exp_mode());
    beat_code = bc[1:0];
    other = side_addr(1 - side);
    drive(side, 1'b1, 1'b0, b);
    @(negedge clk);
    drive(side, 1'b0, 1'b1, b);
    chk("R2", side_addr(side), b);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (hold < 0)        e = b + 32'(k * beat);
      else if (beat > lsz) e = b;
      else                 e = b + 32'((k * beat) % lsz);
      if (hold < 0)        chk("R3", side_addr(side), e);
      else if (beat > lsz) chk("R5", side_addr(side), e);
      else                 chk("R4", side_addr(side), e);
    end
    drive(side, 1'b0, 1'b0, b);
    repeat (3) @(negedge clk);
    chk("R6", side_addr(side), e);
    chk("R10", side_addr(1 - side), other);
    // load and advance together: load wins
    drive(side, 1'b1, 1'b1, b ^ 32'h0000_0A50);
    @(negedge clk);
    drive(side, 1'b0, 1'b0, b);
    chk("R2", side_addr(side), b ^ 32'h0000_0A50);
  endtask

  initial begin
    logic [31:0] bases [3];
    bases[0] = 32'h0000_1000; bases[1] = 32'hFFFF_FFF6; bases[2] = 32'h0000_0037;
    for (int s = 0; s < 2; s++) begin m_en[s] = 1'b0; m_code[s] = 2'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", src_addr, 32'h0);
    chk("R1", dst_addr, 32'h0);
    chk("R1", mode_o, 32'h0);
    // size sweep on both sides, legal and illegal values
    for (int s = 0; s < 2; s++) begin
      for (int sz = 0; sz < 20; sz++) begin
        write_size(s, sz);
        if (sz == 0) chk("R8", mode_o, exp_mode());
        else if (sz == 1 || sz == 2 || sz == 4 || sz == 8) chk("R7", mode_o, exp_mode());
        else chk("R9", mode_o, exp_mode());
      end
      write_size(s, 8);
      write_size(s, 255);
      chk("R9", mode_o, exp_mode());
      write_size(s, 0);
      chk("R8", mode_o, exp_mode());
    end
    repeat (4) @(negedge clk);
    chk("R9", mode_o, exp_mode());
    // address sweep
    for (int s = 0; s < 2; s++)
      for (int h = -1; h < 4; h++)
        for (int bc = 0; bc < 4; bc++)
          for (int bi = 0; bi < 3; bi++)
            run(s, h, bc, bases[bi]);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule